// File: doc/BRIEF.md
# Correlator Channel Status Snapshot Latch

This block collects per-channel accumulation events from twelve correlator channels and presents them to a microprocessor as two 16-bit status words. Each channel keeps a live "fresh data" flag and a live "overrun" flag. The flags software sees are copies of these live flags. The copies are refreshed only on a rising edge of the accumulation interrupt strobe or on a write to a snapshot address. Disabling a channel clears its flags at once.

The second word also carries several system flags. A catch flag is set by any low-going pulse on a discrete input pin, and the live, synchronised level of that pin is shown beside it. A tick flag and a measurement-interrupt flag are also in this word. The measurement flag fires at every tick and again at a programmable number of cycles before the next expected tick. The accumulation interrupt flag sits in the first word. Every system flag clears when its word is read, and a flag that sets in the same cycle as the read is kept. A hard reset clears everything except the pin level. A soft reset clears only the per-channel state.

Top module: `acc_status_latch`

## Requirements
- R1: The visible fresh and overrun bits change only on a rising edge of `acc_int` or on a write (`bus_wr`) to address 2. They hold their value at all other times, except for the clears listed in R4 and R10.
- R2: A channel's live fresh flag sets on `ch_dump`. It clears one cycle after the falling edge of `ch_qp_rd`, or on `ch_acc_clr`. When a dump and a clearing read fall in the same cycle, the dump wins.
- R3: A channel's live overrun flag sets when a dump arrives while its fresh flag is set and not being cleared by a read in that cycle. It stays set until `ch_acc_clr` is asserted.
- R4: Taking `ch_en[i]` low removes channel i's bits from both words in the same cycle. It also clears that channel's live and visible flags, so they read 0 when the channel is enabled again.
- R5: Word A (address 0) is {irq flag in bit 15, zeros in bits 14..12, fresh bits of channels 11..0 in bits 11..0}. The irq flag sets on a rising edge of `acc_int` and clears after a read of word A. A rising edge in the read cycle keeps it set.
- R6: Word B (address 1) bit 15 is the catch flag. It sets if `pin_n` has been low at any moment since the last read of word B, including pulses shorter than a clock period, and shows within two clock edges. Reading word B clears it.
- R7: Word B bit 14 is the level of `pin_n` (1 = high), delayed by two flops. No reset affects it.
- R8: Word B bit 13 sets on `meas_tick` and clears after a read of word B.
- R9: Word B bit 12 sets, only while `irq_en` is high, on `meas_tick` and when `TICK_CYC - PRE_CYC` cycles have passed since the last tick or reset. The second event exists only when `TICK_CYC > PRE_CYC`. Reading word B clears it. Bits 11..0 hold the overrun bits.
- R10: A hard reset (`rst`) clears all flags except the pin level. A soft reset (`soft_rst`) clears the live and visible channel flags but leaves the irq, catch, tick and measurement flags untouched.
- R11: `bus_rdata` shows the word selected by `bus_addr` combinationally. Addresses 2 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hard reset, synchronous, active high |
| soft_rst | input | 1 | Soft reset for the channel flags, active high |
| ch_en | input | 12 | Per-channel enable |
| ch_dump | input | 12 | Per-channel dump pulse |
| ch_qp_rd | input | 12 | Per-channel prompt data read strobe |
| ch_acc_clr | input | 12 | Per-channel accumulator reset write |
| acc_int | input | 1 | Accumulation interrupt strobe, rising edge active |
| meas_tick | input | 1 | Measurement tick pulse |
| irq_en | input | 1 | Interrupt enable for the measurement flag |
| pin_n | input | 1 | Asynchronous discrete input |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe for clear-on-read |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 16 | Selected status word |

## Verification
If a live channel flag is wrong, the ports do not show it until the next snapshot, so the bench forces a snapshot after each stimulus and compares the words then. If a visible flag is wrong, it shows at once in `bus_rdata`, because the read path has no register. A clear-on-read fault shows one cycle after the read. A fault in the catch path shows two clock edges after the pin pulse. A fault in the pre-tick counter shows in exactly one cycle, so the bench checks both sides of that edge.

// File: rtl/acc_status_pkg.sv
package acc_status_pkg;

    localparam int CHAN_COUNT = 12;
    localparam int WORD_W     = 16;

    typedef enum logic [1:0] {
        ADDR_WORD_A = 2'd0,
        ADDR_WORD_B = 2'd1,
        ADDR_SNAP   = 2'd2,
        ADDR_SPARE  = 2'd3
    } acc_addr_e;

    typedef struct packed {
        logic fresh;
        logic missed;
    } chan_flags_t;

    typedef struct packed {
        logic                  irq;
        logic [2:0]            pad;
        logic [CHAN_COUNT-1:0] fresh;
    } word_a_t;

    typedef struct packed {
        logic                  glitch;
        logic                  level;
        logic                  tick;
        logic                  meas;
        logic [CHAN_COUNT-1:0] missed;
    } word_b_t;

    function automatic logic fell(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction

endpackage

// File: rtl/acc_chan_flags.sv
module acc_chan_flags
    import acc_status_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        soft_rst,
    input  logic        en,
    input  logic        dump,
    input  logic        rd_strobe,
    input  logic        acc_clr,
    input  logic        latch,
    output chan_flags_t live,
    output chan_flags_t snap
);

    logic rd_q;
    logic rd_done;

    assign rd_done = fell(rd_q, rd_strobe);

    always_ff @(posedge clk) begin
        if (rst) rd_q <= 1'b0;
        else     rd_q <= rd_strobe;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            live <= '0;
        end else begin
            live.fresh  <= en & (dump | (live.fresh & ~rd_done & ~acc_clr));
            live.missed <= en & ~acc_clr & (live.missed | (dump & live.fresh & ~rd_done));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst || !en) snap <= '0;
        else if (latch)             snap <= live;
    end

endmodule

// File: rtl/acc_pin_monitor.sv
module acc_pin_monitor #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic clr,
    output logic glitch,
    output logic level
);

    logic              caught;
    logic [STAGES-1:0] gsync;
    logic [STAGES-1:0] lsync;
    logic              drop;

    assign glitch = gsync[STAGES-1];
    assign level  = lsync[STAGES-1];
    assign drop   = clr & glitch;

    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n)            caught <= 1'b1;
        else if (rst || drop)  caught <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || drop) gsync <= '0;
        else             gsync <= {gsync[STAGES-2:0], caught};
    end

    always_ff @(posedge clk) begin
        lsync <= {lsync[STAGES-2:0], pin_n};
    end

endmodule

// File: rtl/acc_meas_timer.sv
module acc_meas_timer #(
    parameter int TICK_CYC = 1000,
    parameter int PRE_CYC  = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic pre_hit
);

    generate
        if (TICK_CYC > PRE_CYC) begin : g_pre
            localparam int              CW     = $clog2(TICK_CYC + 1);
            localparam logic [CW-1:0]   CNT_MX = CW'(TICK_CYC);
            localparam logic [CW-1:0]   PRE_AT = CW'(TICK_CYC - PRE_CYC);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst)                cnt <= '0;
                else if (tick)          cnt <= CW'(1);
                else if (cnt != CNT_MX) cnt <= cnt + 1'b1;
            end

            assign pre_hit = (cnt == PRE_AT);
        end else begin : g_nopre
            assign pre_hit = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/acc_status_latch.sv
module acc_status_latch
    import acc_status_pkg::*;
#(
    parameter int TICK_CYC    = 1000,
    parameter int PRE_CYC     = 300,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  soft_rst,
    input  logic [CHAN_COUNT-1:0] ch_en,
    input  logic [CHAN_COUNT-1:0] ch_dump,
    input  logic [CHAN_COUNT-1:0] ch_qp_rd,
    input  logic [CHAN_COUNT-1:0] ch_acc_clr,
    input  logic                  acc_int,
    input  logic                  meas_tick,
    input  logic                  irq_en,
    input  logic                  pin_n,
    input  logic [1:0]            bus_addr,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    output logic [WORD_W-1:0]     bus_rdata
);

    acc_addr_e             addr;
    logic                  acc_int_q;
    logic                  acc_edge;
    logic                  latch_evt;
    logic                  rd_a;
    logic                  rd_b;
    logic                  irq_flag;
    logic                  tick_flag;
    logic                  meas_flag;
    logic                  pre_hit;
    logic                  glitch;
    logic                  level;
    logic [CHAN_COUNT-1:0] live_fresh;
    logic [CHAN_COUNT-1:0] live_missed;
    logic [CHAN_COUNT-1:0] snap_fresh;
    logic [CHAN_COUNT-1:0] snap_missed;
    word_a_t               word_a;
    word_b_t               word_b;

    assign addr      = acc_addr_e'(bus_addr);
    assign acc_edge  = acc_int & ~acc_int_q;
    assign latch_evt = acc_edge | (bus_wr & (addr == ADDR_SNAP));
    assign rd_a      = bus_rd & (addr == ADDR_WORD_A);
    assign rd_b      = bus_rd & (addr == ADDR_WORD_B);

    generate
        for (genvar i = 0; i < CHAN_COUNT; i++) begin : g_ch
            chan_flags_t live_i;
            chan_flags_t snap_i;

            acc_chan_flags u_flags (
                .clk       (clk),
                .rst       (rst),
                .soft_rst  (soft_rst),
                .en        (ch_en[i]),
                .dump      (ch_dump[i]),
                .rd_strobe (ch_qp_rd[i]),
                .acc_clr   (ch_acc_clr[i]),
                .latch     (latch_evt),
                .live      (live_i),
                .snap      (snap_i)
            );

            assign live_fresh[i]  = live_i.fresh;
            assign live_missed[i] = live_i.missed;
            assign snap_fresh[i]  = snap_i.fresh;
            assign snap_missed[i] = snap_i.missed;
        end
    endgenerate

    acc_pin_monitor #(.STAGES(SYNC_STAGES)) u_pin (
        .clk    (clk),
        .rst    (rst),
        .pin_n  (pin_n),
        .clr    (rd_b),
        .glitch (glitch),
        .level  (level)
    );

    acc_meas_timer #(.TICK_CYC(TICK_CYC), .PRE_CYC(PRE_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (meas_tick),
        .pre_hit (pre_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_int_q <= 1'b0;
            irq_flag  <= 1'b0;
            tick_flag <= 1'b0;
            meas_flag <= 1'b0;
        end else begin
            acc_int_q <= acc_int;
            irq_flag  <= acc_edge | (irq_flag & ~rd_a);
            tick_flag <= meas_tick | (tick_flag & ~rd_b);
            meas_flag <= (irq_en & (meas_tick | pre_hit)) | (meas_flag & ~rd_b);
        end
    end

    always_comb begin
        word_a.irq    = irq_flag;
        word_a.pad    = '0;
        word_a.fresh  = snap_fresh & ch_en;
        word_b.glitch = glitch;
        word_b.level  = level;
        word_b.tick   = tick_flag;
        word_b.meas   = meas_flag;
        word_b.missed = snap_missed & ch_en;
        unique case (addr)
            ADDR_WORD_A: bus_rdata = word_a;
            ADDR_WORD_B: bus_rdata = word_b;
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/acc_status_chk.sv
module acc_status_chk
    import acc_status_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  soft_rst,
    input logic                  acc_int,
    input logic                  irq_en,
    input logic                  rd_a,
    input logic                  latch_evt,
    input logic                  irq_flag,
    input logic                  meas_flag,
    input logic [CHAN_COUNT-1:0] ch_en,
    input logic [CHAN_COUNT-1:0] ch_acc_clr,
    input logic [CHAN_COUNT-1:0] live_fresh,
    input logic [CHAN_COUNT-1:0] live_missed,
    input logic [CHAN_COUNT-1:0] snap_fresh,
    input logic [CHAN_COUNT-1:0] snap_missed
);

    // R1
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!latch_evt && !soft_rst && (&ch_en)) |=> ($stable(snap_fresh) && $stable(snap_missed)));

    // R4
    disable_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (~ch_en != '0) |=> (((snap_fresh | snap_missed | live_fresh | live_missed) & $past(~ch_en)) == '0));

    // R3
    missed_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !soft_rst |=> (($past(live_missed & ch_en & ~ch_acc_clr) & ~live_missed) == '0));

    // R5
    irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(acc_int) |=> irq_flag);

    // R9
    meas_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_en && !meas_flag) |=> !meas_flag);

    // R10
    soft_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && irq_flag && !rd_a) |=> irq_flag);

endmodule

bind acc_status_latch acc_status_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .soft_rst    (soft_rst),
    .acc_int     (acc_int),
    .irq_en      (irq_en),
    .rd_a        (rd_a),
    .latch_evt   (latch_evt),
    .irq_flag    (irq_flag),
    .meas_flag   (meas_flag),
    .ch_en       (ch_en),
    .ch_acc_clr  (ch_acc_clr),
    .live_fresh  (live_fresh),
    .live_missed (live_missed),
    .snap_fresh  (snap_fresh),
    .snap_missed (snap_missed)
);

// File: tb/tb_acc_status_latch.sv
`timescale 1ns/1ps
module tb_acc_status_latch;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic [11:0] ch_en = '1;
    logic [11:0] ch_dump = '0;
    logic [11:0] ch_qp_rd = '0;
    logic [11:0] ch_acc_clr = '0;
    logic        acc_int = 1'b0;
    logic        meas_tick = 1'b0;
    logic        irq_en = 1'b1;
    logic        pin_n = 1'b1;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    acc_status_latch #(.TICK_CYC(40), .PRE_CYC(10), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .ch_en(ch_en),
        .ch_dump(ch_dump), .ch_qp_rd(ch_qp_rd), .ch_acc_clr(ch_acc_clr),
        .acc_int(acc_int), .meas_tick(meas_tick), .irq_en(irq_en),
        .pin_n(pin_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_rdata(bus_rdata)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        bus_addr = a;
        bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic snap();
        bus_addr = 2'd2;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic dump_ch(input int c);
        ch_dump[c] = 1'b1;
        @(negedge clk);
        ch_dump[c] = 1'b0;
    endtask

    task automatic qp_read(input int c);
        ch_qp_rd[c] = 1'b1;
        @(negedge clk);
        ch_qp_rd[c] = 1'b0;
        cyc(2);
    endtask

    task automatic clr_ch(input int c);
        ch_acc_clr[c] = 1'b1;
        @(negedge clk);
        ch_acc_clr[c] = 1'b0;
    endtask

    task automatic pulse_int();
        acc_int = 1'b1;
        @(negedge clk);
        acc_int = 1'b0;
    endtask

    task automatic pulse_tick();
        meas_tick = 1'b1;
        @(negedge clk);
        meas_tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        peek(2'd0, v); chk("R10 word A after reset", v, 16'h0000);
        peek(2'd1, v); chk("R10/R7 word B after reset", v, 16'h4000);
        peek(2'd3, v); chk("R11 spare address", v, 16'h0000);
    endtask

    task automatic t_latch();
        logic [15:0] v;
        dump_ch(3);
        cyc(1);
        peek(2'd0, v); chk("R1 no latch without event", v, 16'h0000);
        pulse_int();
        peek(2'd0, v); chk("R5 irq and fresh after edge", v, 16'h8008);
        rd(2'd0, v);   chk("R5 read returns word A", v, 16'h8008);
        peek(2'd0, v); chk("R5 irq cleared by read", v, 16'h0008);
        qp_read(3);
        peek(2'd0, v); chk("R1 held after live clear", v, 16'h0008);
        snap();
        peek(2'd0, v); chk("R2 cleared by read trailing edge", v, 16'h0000);
    endtask

    task automatic t_missed();
        logic [15:0] v;
        dump_ch(5);
        dump_ch(5);
        snap();
        peek(2'd0, v); chk("R2 fresh ch5", v, 16'h0020);
        peek(2'd1, v); chk("R3 overrun ch5", v & 16'h0FFF, 16'h0020);
        qp_read(5);
        snap();
        peek(2'd0, v); chk("R2 fresh ch5 cleared", v, 16'h0000);
        peek(2'd1, v); chk("R3 overrun sticky after read", v & 16'h0FFF, 16'h0020);
        clr_ch(5);
        snap();
        peek(2'd1, v); chk("R3 overrun cleared by acc reset", v & 16'h0FFF, 16'h0000);
    endtask

    task automatic t_disable();
        logic [15:0] v;
        dump_ch(7);
        dump_ch(7);
        snap();
        peek(2'd0, v); chk("R4 setup fresh ch7", v, 16'h0080);
        ch_en[7] = 1'b0;
        peek(2'd0, v); chk("R4 fresh gone at once", v, 16'h0000);
        peek(2'd1, v); chk("R4 overrun gone at once", v & 16'h0FFF, 16'h0000);
        cyc(1);
        ch_en[7] = 1'b1;
        peek(2'd1, v); chk("R4 overrun stays clear on enable", v & 16'h0FFF, 16'h0000);
        snap();
        peek(2'd0, v); chk("R4 live flag cleared", v, 16'h0000);
    endtask

    task automatic t_dump_wins();
        logic [15:0] v;
        dump_ch(2);
        ch_qp_rd[2] = 1'b1;
        @(negedge clk);
        ch_qp_rd[2] = 1'b0;
        ch_dump[2] = 1'b1;
        @(negedge clk);
        ch_dump[2] = 1'b0;
        cyc(1);
        snap();
        peek(2'd0, v); chk("R2 dump wins over read", v & 16'h0FFF, 16'h0004);
        peek(2'd1, v); chk("R3 no overrun when read same cycle", v & 16'h0FFF, 16'h0000);
        clr_ch(2);
    endtask

    task automatic t_set_wins();
        logic [15:0] v;
        bus_addr = 2'd0;
        bus_rd = 1'b1;
        acc_int = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        acc_int = 1'b0;
        peek(2'd0, v); chk("R5 set during read kept", v & 16'h8000, 16'h8000);
        rd(2'd0, v);
        peek(2'd0, v); chk("R5 cleared by later read", v & 16'h8000, 16'h0000);
    endtask

    task automatic t_glitch();
        logic [15:0] v;
        rd(2'd1, v);
        #1 pin_n = 1'b0;
        #1 pin_n = 1'b1;
        cyc(1);
        cyc(1);
        peek(2'd1, v); chk("R6 short pulse caught", v & 16'hC000, 16'hC000);
        rd(2'd1, v);
        peek(2'd1, v); chk("R6 cleared on read", v & 16'h8000, 16'h0000);
        pin_n = 1'b0;
        cyc(3);
        peek(2'd1, v); chk("R7 level low", v & 16'hC000, 16'h8000);
        pin_n = 1'b1;
        cyc(3);
        rd(2'd1, v);
        peek(2'd1, v); chk("R7 level high, R6 clear", v & 16'hC000, 16'h4000);
    endtask

    task automatic t_tick();
        logic [15:0] v;
        irq_en = 1'b1;
        pulse_tick();
        peek(2'd1, v); chk("R8 tick and R9 meas set", v & 16'h3000, 16'h3000);
        rd(2'd1, v);
        peek(2'd1, v); chk("R8 tick cleared on read", v & 16'h3000, 16'h0000);
        cyc(28);
        peek(2'd1, v); chk("R9 meas not yet before pre point", v & 16'h3000, 16'h0000);
        cyc(1);
        peek(2'd1, v); chk("R9 meas at pre point", v & 16'h3000, 16'h1000);
        rd(2'd1, v);
        irq_en = 1'b0;
        pulse_tick();
        peek(2'd1, v); chk("R9 meas gated by irq_en", v & 16'h3000, 16'h2000);
        rd(2'd1, v);
        irq_en = 1'b1;
    endtask

    task automatic t_resets();
        logic [15:0] v;
        dump_ch(1);
        pulse_int();
        pulse_tick();
        peek(2'd0, v); chk("R10 setup word A", v, 16'h8002);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        peek(2'd0, v); chk("R10 soft reset keeps irq", v, 16'h8000);
        peek(2'd1, v); chk("R10 soft reset keeps tick", v & 16'h2000, 16'h2000);
        snap();
        peek(2'd0, v); chk("R10 soft reset cleared live flag", v, 16'h8000);
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        peek(2'd0, v); chk("R10 hard reset word A", v, 16'h0000);
        peek(2'd1, v); chk("R10/R7 hard reset word B", v, 16'h4000);
    endtask

    initial begin
        cyc(4);
        rst = 1'b0;
        t_reset();
        rd(2'd1, bus_rdata_dummy);
        t_latch();
        cyc(40);
        begin
            logic [15:0] v;
            rd(2'd1, v);
        end
        t_missed();
        t_disable();
        t_dump_wins();
        t_set_wins();
        t_glitch();
        t_tick();
        t_resets();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    logic [15:0] bus_rdata_dummy;

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule